// File: doc/BRIEF.md
# Segmented Carry-Tree Binary Adder

This block adds two unsigned operands of a parameterised width and a carry-in. It produces the sum and the carry-out. The result is held in output registers, so it appears one clock after the operands are sampled. A parameter can remove the registers and make the path purely combinational.

The adder works in three stages. The first stage forms a generate and a propagate bit for each bit position. It then merges them into one group pair for each 4-bit segment. The carry-in is folded into the generate term of bit 0.

The second stage is a logarithmic-depth prefix network over the segment pairs. It has one level for each doubling of span. It uses black cells where the group propagate is still needed, and gray cells where a span has already reached bit 0. The network therefore gives the carry into every fourth bit position, and no other carries.

The third stage is one 4-bit ripple chain per segment. Each chain starts from its segment carry and produces the four sum bits of that segment. The carry-out is the group generate across the full width.

Top module: `spks_adder`

## Requirements
- R1: One clock after the operands and carry-in are sampled (outside reset), `sum` equals the low WIDTH bits of a + b + cin.
- R2: One clock after sampling, `cout` equals bit WIDTH of a + b + cin, that is, the carry out of the most significant position.
- R3: `rst` is synchronous and active-high. After a clock edge with `rst` high, `sum` is all zeros and `cout` is 0, whatever the operands are.
- R4: The carry that the tree delivers into bit position 4k (k = 1 .. WIDTH/4-1) equals the carry out of the low 4k bits of a + b + cin. At the ports, an operand of 4k ones plus cin=1 yields a sum of exactly 2^(4k).
- R5: When every bit position propagates (a XOR b is all ones) and cin=1, the next `sum` is all zeros and the next `cout` is 1. This is the longest carry path.
- R6: When b is zero and cin=0, the next `sum` equals a and the next `cout` is 0.
- R7: WIDTH may be any multiple of 4. Widths of 16, 32 and 64 give correct results under the same stimulus.
- R8: A new operand set may be applied every clock. Each result belongs to the operands sampled at the immediately preceding edge, with no mixing between consecutive vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; results update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the result registers |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Registered low WIDTH bits of the sum |
| cout | output | 1 | Registered carry out of the top bit |

## Verification
The bound checker tests the registered sum and carry against the arithmetic sum of the previous cycle's inputs on every cycle. It also tests each internal segment carry against the carry out of the low bits below that boundary. The reset clearing, the full-propagate chain and the identity case are checked whenever those conditions arise.

Only the bench's scenarios show that the three supported widths agree under identical stimulus. The same holds for the walking carries that cross each segment boundary in turn, back-to-back vectors with no mixing, and a reset applied mid-stream while the operands are nonzero.

// File: rtl/spks_pkg.sv
package spks_pkg;
  // Bits per ripple segment; the tree only resolves carries at multiples of this.
  localparam int SEG_W = 4;

  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Black cell: merges a higher span with the span just below it.
  function automatic gp_t gp_black(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Gray cell: only the group generate is kept.
  function automatic logic gp_gray(gp_t hi, gp_t lo);
    return hi.g | (hi.p & lo.g);
  endfunction
endpackage

// File: rtl/spks_gp_stage.sv
module spks_gp_stage
  import spks_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int NSEG = WIDTH / SEG_W
) (
  input  logic [WIDTH-1:0]      a,
  input  logic [WIDTH-1:0]      b,
  input  logic                  cin,
  output logic [WIDTH-1:0]      bit_g,
  output logic [WIDTH-1:0]      bit_p,
  output gp_t  [NSEG-1:0]       seg_gp
);
  assign bit_g = a & b;
  assign bit_p = a ^ b;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic first_g;
    gp_t  acc;

    if (s == 0) begin : g_fold
      // Carry-in folded into the lowest generate term.
      assign first_g = bit_g[0] | (bit_p[0] & cin);
    end else begin : g_plain
      assign first_g = bit_g[s*SEG_W];
    end

    always_comb begin
      acc = gp_t'{g: first_g, p: bit_p[s*SEG_W]};
      for (int i = 1; i < SEG_W; i++) begin
        acc = gp_black(gp_t'{g: bit_g[s*SEG_W+i], p: bit_p[s*SEG_W+i]}, acc);
      end
    end

    assign seg_gp[s] = acc;
  end
endmodule

// File: rtl/spks_prefix_tree.sv
module spks_prefix_tree
  import spks_pkg::*;
#(
  parameter int NSEG = 8,
  localparam int LVLS = $clog2(NSEG)
) (
  input  gp_t  [NSEG-1:0] seg_gp,
  output logic [NSEG-1:0] grp_g
);
  gp_t [NSEG-1:0] lvl [LVLS+1];

  assign lvl[0] = seg_gp;

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int D = 1 << l;
    for (genvar j = 0; j < NSEG; j++) begin : g_node
      if (j < D) begin : g_pass
        assign lvl[l+1][j] = lvl[l][j];
      end else if (j < 2*D) begin : g_gray
        // Lower span reaches segment 0: only the generate is needed afterwards.
        assign lvl[l+1][j] = gp_t'{g: gp_gray(lvl[l][j], lvl[l][j-D]), p: 1'b0};
      end else begin : g_black
        assign lvl[l+1][j] = gp_black(lvl[l][j], lvl[l][j-D]);
      end
    end
  end

  for (genvar j = 0; j < NSEG; j++) begin : g_out
    assign grp_g[j] = lvl[LVLS][j].g;
  end
endmodule

// File: rtl/spks_ripple_seg.sv
module spks_ripple_seg
  import spks_pkg::*;
(
  input  logic [SEG_W-1:0] g,
  input  logic [SEG_W-1:0] p,
  input  logic             c_in,
  output logic [SEG_W-1:0] s,
  output logic             c_out
);
  logic [SEG_W:0] c;

  always_comb begin
    c[0] = c_in;
    for (int i = 0; i < SEG_W; i++) begin
      c[i+1] = g[i] | (p[i] & c[i]);
    end
  end

  assign s     = p ^ c[SEG_W-1:0];
  assign c_out = c[SEG_W];
endmodule

// File: rtl/spks_adder.sv
module spks_adder
  import spks_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NSEG = WIDTH / SEG_W;

  if (WIDTH % SEG_W != 0 || WIDTH < SEG_W) begin : g_bad_width
    $error("spks_adder: WIDTH must be a positive multiple of the segment size");
  end

  logic [WIDTH-1:0] bit_g, bit_p, sum_c;
  gp_t  [NSEG-1:0]  seg_gp;
  logic [NSEG-1:0]  grp_g;
  logic [NSEG-1:0]  seg_cin;
  logic [NSEG-1:0]  rip_cout;
  logic             cout_c;

  spks_gp_stage #(.WIDTH(WIDTH)) u_gp (
    .a      (a),
    .b      (b),
    .cin    (cin),
    .bit_g  (bit_g),
    .bit_p  (bit_p),
    .seg_gp (seg_gp)
  );

  spks_prefix_tree #(.NSEG(NSEG)) u_tree (
    .seg_gp (seg_gp),
    .grp_g  (grp_g)
  );

  assign seg_cin[0] = cin;
  for (genvar k = 1; k < NSEG; k++) begin : g_cin
    assign seg_cin[k] = grp_g[k-1];
  end
  assign cout_c = grp_g[NSEG-1];

  for (genvar k = 0; k < NSEG; k++) begin : g_rip
    spks_ripple_seg u_seg (
      .g     (bit_g[k*SEG_W +: SEG_W]),
      .p     (bit_p[k*SEG_W +: SEG_W]),
      .c_in  (seg_cin[k]),
      .s     (sum_c[k*SEG_W +: SEG_W]),
      .c_out (rip_cout[k])
    );
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        sum  <= '0;
        cout <= 1'b0;
      end else begin
        sum  <= sum_c;
        cout <= cout_c;
      end
    end
  end else begin : g_comb
    assign sum  = sum_c;
    assign cout = cout_c;
  end
endmodule

// File: rtl/spks_adder_chk.sv
module spks_adder_chk
  import spks_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int NSEG = WIDTH / SEG_W
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NSEG-1:0]  seg_cin,
  input logic [NSEG-1:0]  rip_cout
);
  logic [WIDTH:0] ext_total;
  assign ext_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  // R4: tree carry at each boundary equals the carry out of the bits below it,
  // and each ripple segment's own carry-out agrees with the next tree carry.
  for (genvar k = 1; k < NSEG; k++) begin : g_seg_chk
    localparam int LB = k * SEG_W;
    logic [LB:0] part;
    assign part = {1'b0, a[LB-1:0]} + {1'b0, b[LB-1:0]} + {{LB{1'b0}}, cin};

    assert_seg_carry_R4: assert property (@(posedge clk) disable iff (rst)
      seg_cin[k] == part[LB]);
    assert_ripple_agree_R4: assert property (@(posedge clk) disable iff (rst)
      rip_cout[k-1] == seg_cin[k]);
  end

  if (REG_OUT) begin : g_seq
    logic [WIDTH:0] ext_q;
    always_ff @(posedge clk) ext_q <= ext_total;

    assert_reset_clear_R3: assert property (@(posedge clk)
      rst |=> (sum == '0 && !cout));
    assert_sum_R1: assert property (@(posedge clk) disable iff (rst)
      !rst |=> sum == ext_q[WIDTH-1:0]);
    assert_cout_R2: assert property (@(posedge clk) disable iff (rst)
      !rst |=> cout == ext_q[WIDTH]);
    assert_full_chain_R5: assert property (@(posedge clk) disable iff (rst)
      ((a ^ b) == '1 && cin) |=> (sum == '0 && cout));
    assert_identity_R6: assert property (@(posedge clk) disable iff (rst)
      (b == '0 && !cin) |=> (sum == $past(a) && !cout));
  end
endmodule

bind spks_adder spks_adder_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a        (a),
  .b        (b),
  .cin      (cin),
  .sum      (sum),
  .cout     (cout),
  .seg_cin  (seg_cin),
  .rip_cout (rip_cout)
);

// File: tb/spks_adder_tb.sv
`timescale 1ns/1ps
module spks_adder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [63:0] a = '0, b = '0;
  logic cin = 1'b0;

  logic [15:0] sum16; logic cout16;
  logic [31:0] sum32; logic cout32;
  logic [63:0] sum64; logic cout64;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spks_adder #(.WIDTH(32)) u_dut (
    .clk(clk), .rst(rst), .a(a[31:0]), .b(b[31:0]), .cin(cin),
    .sum(sum32), .cout(cout32));
  spks_adder #(.WIDTH(16)) u_dut16 (
    .clk(clk), .rst(rst), .a(a[15:0]), .b(b[15:0]), .cin(cin),
    .sum(sum16), .cout(cout16));
  spks_adder #(.WIDTH(64)) u_dut64 (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin),
    .sum(sum64), .cout(cout64));

  typedef struct {
    logic [16:0] e16;
    logic [32:0] e32;
    logic [64:0] e64;
    string       req;
  } exp_t;
  exp_t q[$];

  task automatic check_val(string req, logic [64:0] act, logic [64:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: applies one vector and queues the expected results of all widths.
  task automatic drive(logic [63:0] va, logic [63:0] vb, logic vc, string req);
    exp_t it;
    @(negedge clk);
    a = va; b = vb; cin = vc;
    it.e16 = {1'b0, va[15:0]} + {1'b0, vb[15:0]} + {16'b0, vc};
    it.e32 = {1'b0, va[31:0]} + {1'b0, vb[31:0]} + {32'b0, vc};
    it.e64 = {1'b0, va} + {1'b0, vb} + {64'b0, vc};
    it.req = req;
    q.push_back(it);
  endtask

  // Monitor: each rising edge consumes the vector applied before it.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      check_val({it.req, " w16"}, {48'b0, cout16, sum16}, {48'b0, it.e16});
      check_val({it.req, " w32"}, {32'b0, cout32, sum32}, {32'b0, it.e32});
      check_val({it.req, " w64"}, {cout64, sum64}, it.e64);
    end
  end

  task automatic check_reset_state(string req);
    check_val({req, " w16"}, {48'b0, cout16, sum16}, 65'b0);
    check_val({req, " w32"}, {32'b0, cout32, sum32}, 65'b0);
    check_val({req, " w64"}, {cout64, sum64}, 65'b0);
  endtask

  initial begin
    // R3: reset held over several edges
    rst = 1'b1;
    a = 64'hFFFF_FFFF_FFFF_FFFF; b = 64'h1; cin = 1'b1;
    repeat (3) @(posedge clk);
    #2 check_reset_state("R3 initial reset");
    @(negedge clk) rst = 1'b0;

    // R6: identity with b=0, cin=0
    drive(64'h0123_4567_89AB_CDEF, 64'h0, 1'b0, "R6 identity");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, "R6 identity ones");
    drive(64'h0, 64'h0, 1'b0, "R6 zero");

    // R5: every position propagates, cin=1
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, "R5 all-ones chain");
    drive(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, "R5 alternating chain");
    drive(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R5 chain via b");

    // R4: carry crossing each segment boundary in turn
    for (int k = 1; k < 16; k++) begin
      drive((64'h1 << (4*k)) - 64'h1, 64'h0, 1'b1, "R4 boundary carry");
      drive(64'h1 << (4*k-1), 64'h1 << (4*k-1), 1'b0, "R4 boundary generate");
    end

    // R2: carry-out with and without cin
    drive(64'h8000_0000_0000_8000, 64'h8000_0000_8000_8000, 1'b0, "R2 top generate");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R2 max operands");

    // R1/R7/R8: back-to-back random vectors
    for (int i = 0; i < 400; i++) begin
      drive({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 R7 R8 random");
    end

    // R3: reset mid-stream with busy operands
    @(negedge clk);
    rst = 1'b1;
    a = 64'hDEAD_BEEF_CAFE_F00D; b = 64'h1234_5678_9ABC_DEF0; cin = 1'b1;
    @(posedge clk);
    #2 check_reset_state("R3 mid-run reset");
    @(negedge clk) rst = 1'b0;

    drive(64'h7, 64'h9, 1'b0, "R8 after reset");
    drive(64'h0000_0000_FFFF_FFFF, 64'h0, 1'b1, "R4 R8 after reset");
    repeat (3) @(posedge clk);
    #3;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule